// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a down-counting interval timer that runs in one-shot or periodic mode. A 1 MHz tick-enable input, running off the core clock, paces it. Two 32-bit registers on a small register bus control it. The configuration word carries an enable bit, a mode bit and a count field. The count field holds the wanted interval minus one, so an interval of N ticks is programmed as N-1, and an interval of 0 or 1 tick is programmed as 0. A rate of HZ events per second is therefore programmed as 1000000/HZ - 1.

When an enabled count has reached zero and one more tick arrives, the timer sets an interrupt flag. The flag drives an active-high, level-sensitive interrupt pin until software clears it by writing a one to bit 30 of the status register. In periodic mode the counter then reloads the programmed value and keeps running. In one-shot mode the enable bit clears and the counter stays at zero.

The register bus is a control port with no back-pressure. Every request is taken in the cycle it is presented. A read returns its data with a one-cycle response strobe, and that data is captured at the same edge that accepts the request.

Top module: `interval_timer`

## Requirements
- R1: After reset the config register reads 0x00000000, the status register reads 0x00000000 and the interrupt pin is low.
- R2: The config register sits at byte offset 0x0. Bit 31 is enable, bit 30 is periodic mode (1) or one-shot (0), bit 29 is stored and read back unchanged, and bits 28:0 are the count. A write with bit 31 set loads the counter at once. A write with bit 31 clear, including a write of 0, halts the counter at its current value.
- R3: After an enabling write of count N-1, the interrupt rises after exactly N ticks and not before.
- R4: The counter decrements by one only in cycles where the tick input is high and the timer is enabled. It holds in all other cycles.
- R5: In one-shot mode an expiry clears bit 31 of the config register and leaves the counter at 0. Later ticks change nothing.
- R6: In periodic mode an expiry reloads the count field, and the interrupt recurs every N ticks.
- R7: The status register sits at byte offset 0x4. Bits 28:0 are the live count, bit 30 is the interrupt flag, and all other bits read 0. The interrupt pin always equals the flag.
- R8: A status write with bit 30 set clears the flag. A status write with bit 30 clear has no effect.
- R9: A clear write in the same cycle as an expiry leaves the flag set.
- R10: A config write in the same cycle as a tick loads the written count without decrementing it, and no expiry occurs in that cycle.
- R11: Writes to any other offset are ignored. Reads from any other offset return 0.
- R12: `rd_valid` pulses exactly one cycle after each read request and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 1 MHz tick enable |
| bus_en | input | 1 | Register request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data |
| irq | output | 1 | Level-high interrupt |

## Verification
The counter is exercised in several ways:
- **One-shot run.** A short one-shot count is sampled one tick before and one tick after expiry, which shows whether the N-1 encoding is off by one.
- **Periodic run.** A periodic count shows whether the reload happens and whether the spacing between interrupts is correct.
- **Idle cycles without a tick.** These separate decrementing on every clock from decrementing only on ticks.
- **Disabled timer.** Ticks with the timer disabled show that the counter halts.

Two same-cycle collisions are driven on purpose: a clear against an expiry, and a load against a tick. These show which source wins each case. Writes to unmapped offsets, and status writes without bit 30 set, are followed by read-back to show that no state moved.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int TMR_DATA_W = 32;
  localparam int TMR_CNT_W  = 29;
  localparam int TMR_ADDR_W = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 29,
  parameter int PER_BIT = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld_wr,
  input  logic              ld_en,
  input  logic [DATA_W-2:0] ld_word,
  output logic              en,
  output logic [DATA_W-2:0] cfg_word,
  output logic [CNT_W-1:0]  count,
  output logic              expire
);
  logic             per;
  logic [CNT_W-1:0] reload;

  assign per    = cfg_word[PER_BIT];
  assign reload = cfg_word[CNT_W-1:0];
  assign expire = en && tick && !ld_wr && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      cfg_word <= '0;
      count    <= '0;
    end else if (ld_wr) begin
      en       <= ld_en;
      cfg_word <= ld_word;
      if (ld_en) count <= ld_word[CNT_W-1:0];
    end else if (en && tick) begin
      if (count == '0) begin
        if (per) count <= reload;
        else     en    <= 1'b0;
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  a_r2_load_now: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wr && ld_en) |=> (en && count == $past(ld_word[CNT_W-1:0])));
  a_r2_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wr && !ld_en) |=> (!en && $stable(count)));
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !ld_wr && count != '0) |=> (count == CNT_W'($past(count) - 1'b1)));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_wr) |=> $stable(count));
  a_r5_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !per) |=> (!en && count == '0));
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && per) |=> (en && count == $past(reload)));
endmodule

// File: rtl/timer_irq.sv
module timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_wr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (expire) flag <= 1'b1;
    else if (clr_wr) flag <= 1'b0;
  end

  a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !flag);
  a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && !expire) |=> $stable(flag));
  a_r9_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && expire) |=> flag);
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int CNT_W    = 29,
  parameter int CFG_OFF  = 0,
  parameter int STAT_OFF = 4,
  parameter int CLR_BIT  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              en,
  input  logic [DATA_W-2:0] cfg_word,
  input  logic [CNT_W-1:0]  count,
  input  logic              flag,
  output logic              ld_wr,
  output logic              ld_en,
  output logic [DATA_W-2:0] ld_word,
  output logic              clr_wr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int EN_BIT = DATA_W - 1;

  reg_sel_e          sel;
  logic              rd_req;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] stat_word;

  always_comb begin
    if (bus_addr == ADDR_W'(CFG_OFF))       sel = SEL_CFG;
    else if (bus_addr == ADDR_W'(STAT_OFF)) sel = SEL_STAT;
    else                                    sel = SEL_NONE;
  end

  assign rd_req  = bus_en && !bus_we;
  assign ld_wr   = bus_en && bus_we && (sel == SEL_CFG);
  assign ld_en   = bus_wdata[EN_BIT];
  assign ld_word = bus_wdata[DATA_W-2:0];
  assign clr_wr  = bus_en && bus_we && (sel == SEL_STAT) && bus_wdata[CLR_BIT];

  always_comb begin
    stat_word              = '0;
    stat_word[CNT_W-1:0]   = count;
    stat_word[CLR_BIT]     = flag;
  end

  always_comb begin
    case (sel)
      SEL_CFG:  rd_next = {en, cfg_word};
      SEL_STAT: rd_next = stat_word;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_next;
    end
  end

  a_r12_answer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  a_r11_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && sel == SEL_NONE) |-> (!ld_wr && !clr_wr));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int DATA_W   = TMR_DATA_W,
  parameter int ADDR_W   = TMR_ADDR_W,
  parameter int CNT_W    = TMR_CNT_W,
  parameter int CFG_OFF  = 0,
  parameter int STAT_OFF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int MODE_BIT = DATA_W - 2;

  logic              ld_wr, ld_en, clr_wr, en, expire, flag;
  logic [DATA_W-2:0] ld_word, cfg_word;
  logic [CNT_W-1:0]  count;

  timer_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .CFG_OFF(CFG_OFF), .STAT_OFF(STAT_OFF), .CLR_BIT(MODE_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .en(en), .cfg_word(cfg_word), .count(count), .flag(flag),
    .ld_wr(ld_wr), .ld_en(ld_en), .ld_word(ld_word), .clr_wr(clr_wr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  timer_counter #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PER_BIT(MODE_BIT)
  ) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ld_wr(ld_wr), .ld_en(ld_en), .ld_word(ld_word),
    .en(en), .cfg_word(cfg_word), .count(count), .expire(expire)
  );

  timer_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr_wr(clr_wr), .flag(flag)
  );

  assign irq = flag;

  a_r7_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en && tick));
endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  interval_timer i_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each read response is compared against the queue head
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        total++; failed++;
        $display("FAIL R12 actual=unexpected response 0x%08h expected=none", rd_data);
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rd_data, e);
      end
    end
  end

  task automatic wrt(input logic [3:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick = tk;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wrt(a, d, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(req);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", {31'd0, irq}, 32'd0);
    rd(4'h0, 32'h0000_0000, "R1");
    rd(4'h4, 32'h0000_0000, "R1");
    @(negedge clk);
    chk("R12", {31'd0, rd_valid}, 32'd0);

    // one-shot, N = 5
    wr(4'h0, 32'h8000_0004);
    rd(4'h4, 32'h0000_0004, "R2");
    ticks(4);
    chk("R3", {31'd0, irq}, 32'd0);
    rd(4'h4, 32'h0000_0000, "R3");
    ticks(1);
    chk("R3", {31'd0, irq}, 32'd1);
    rd(4'h0, 32'h0000_0004, "R5");
    ticks(3);
    rd(4'h4, 32'h4000_0000, "R5");
    chk("R7", {31'd0, irq}, 32'd1);

    // clear behaviour
    wr(4'h4, 32'hBFFF_FFFF);
    chk("R8", {31'd0, irq}, 32'd1);
    wr(4'h4, 32'h4000_0000);
    chk("R8", {31'd0, irq}, 32'd0);
    rd(4'h4, 32'h0000_0000, "R8");

    // periodic, N = 3
    wr(4'h0, 32'hC000_0002);
    ticks(3);
    chk("R6", {31'd0, irq}, 32'd1);
    rd(4'h4, 32'h4000_0002, "R6");
    wr(4'h4, 32'h4000_0000);
    ticks(2);
    chk("R6", {31'd0, irq}, 32'd0);
    ticks(1);
    chk("R6", {31'd0, irq}, 32'd1);
    wr(4'h4, 32'h4000_0000);

    // decrement only on ticks
    wr(4'h0, 32'h8000_0007);
    repeat (6) @(negedge clk);
    rd(4'h4, 32'h0000_0007, "R4");
    ticks(3);
    rd(4'h4, 32'h0000_0004, "R4");

    // stop with a zero write
    wr(4'h0, 32'h0000_0000);
    ticks(5);
    rd(4'h4, 32'h0000_0004, "R2");
    chk("R2", {31'd0, irq}, 32'd0);
    rd(4'h0, 32'h0000_0000, "R2");
    wr(4'h0, 32'h2000_0003);
    rd(4'h0, 32'h2000_0003, "R2");
    rd(4'h4, 32'h0000_0004, "R2");

    // clear colliding with expiry
    wr(4'h0, 32'hC000_0000);
    wrt(4'h4, 32'h4000_0000, 1'b1);
    chk("R9", {31'd0, irq}, 32'd1);
    wr(4'h4, 32'h4000_0000);
    chk("R9", {31'd0, irq}, 32'd0);

    // load colliding with a tick
    wrt(4'h0, 32'hC000_0009, 1'b1);
    chk("R10", {31'd0, irq}, 32'd0);
    rd(4'h4, 32'h0000_0009, "R10");

    // unmapped offsets
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h1, 32'h4000_0000);
    rd(4'h0, 32'hC000_0009, "R11");
    rd(4'h4, 32'h0000_0009, "R11");
    rd(4'h8, 32'h0000_0000, "R11");
    chk("R11", {31'd0, irq}, 32'd0);

    repeat (3) @(negedge clk);
    chk("R12", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule